// File: doc/BRIEF.md
# Shared-RAM Text Display Controller

This block turns a character buffer held in a shared 1024 x 8 RAM into a serial pixel stream for an alphanumeric raster. It runs on a single dot clock at twice the processor rate. A 3-bit dot counter divides that clock by eight to form the character clock. A 12-bit character-position counter then provides the column, glyph scanline and text row. For every character position the block fetches the character code, looks up one glyph row in an internal table and shifts it out most-significant bit first.

The processor and the display share the RAM without wait states. An input phase flag, high in alternate dot-clock cycles, marks the processor half of each master-clock cycle. In that half the processor port owns the RAM. In the other half the display fetch owns it. The screen is 32 columns by 16 text rows of 8 scanlines each. This fills the 512-byte display region in the upper half of the RAM exactly.

Top module: `txd_display`

## Requirements
- R1: Synchronous active-low reset. After one clock edge with `rst_n` low, `video`, `hsync` and `cpu_rdata` are 0 and `frame_sync` is 1, because the position counter is at 0.
- R2: The dot counter advances every clock and wraps from 7 to 0. The 12-bit position counter advances after dot 7 and wraps from 4095 to 0. Position bits [4:0] are the column, [7:5] the scanline and [11:8] the text row.
- R3: `cpu_half` must toggle every clock. A write (`cpu_we`=1) is performed only in a cycle with `cpu_half`=1. A write presented while `cpu_half`=0 leaves the RAM unchanged.
- R4: At the clock edge that ends a cycle with `cpu_half`=1, `cpu_rdata` loads the RAM byte at `cpu_addr`. It holds through the following display cycle, so read data is valid in the cycle after the processor half.
- R5: The code for text row r and column c is read from RAM address 0x200 + 32*r + c. Display reads occur only in cycles with `cpu_half`=0 and only inside 0x200..0x3FF.
- R6: Counting cycles from the first cycle after reset, cycle n shows position P = (n/8) mod 4096 at dot d = n mod 8. `video` in that cycle equals bit (7-d) of the glyph row for the code of P at scanline P[7:5]. The only exception is position 0 of the first frame after reset, which is dark.
- R7: Glyph rows by code: 0x20 gives 0x00; 0x7F gives 0xFF; 0x7C gives 0x18; 0x2D gives 0xFF on scanline 3 and 0x00 elsewhere; 0x23 gives 0xAA on even scanlines and 0x55 on odd ones. Any other code gives 0xFF on scanlines 0 and 7 and 0x81 elsewhere.
- R8: `hsync` is 1 exactly while the column is at least 32 - `HBLANK_COLS` (columns 28..31 by default). `video` is 0 while `hsync` is 1.
- R9: `frame_sync` is 1 exactly while the position counter is 0, which spans the first 8 dots of each frame.
- R10: All 1024 RAM addresses, including the display region, can be written and read back through the processor port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock, twice the processor master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_half | input | 1 | High in the processor half of each master-clock cycle |
| cpu_addr | input | 10 | Processor RAM address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write enable, honoured only when `cpu_half` is high |
| cpu_rdata | output | 8 | Processor read data, loaded at the end of the processor half |
| video | output | 1 | Serial pixel, most-significant glyph bit first |
| hsync | output | 1 | High during the blanking columns at the end of each scanline |
| frame_sync | output | 1 | High during character position 0 |

## Verification
Read data is due one edge after the processor cycle that presents the address. The bench drives the address at the falling edge that opens a `cpu_half` cycle and samples `cpu_rdata` at the next falling edge. The pixel for position P and dot d is due in the same cycle n = 8P + d, because the glyph row is loaded one character early at dot 7. The bench keeps its own cycle count from reset release and compares `video`, `hsync` and `frame_sync` against a model at every falling edge of a whole frame. It does this only after all display writes have finished, so that no fetch of stale data can fall inside the compared window. The reset and first-frame dark position are checked right after release, where the expected values are fixed.

// File: rtl/txd_pkg.sv
// Package: shared widths of the text display controller.
// Assumes a 32 x 16 character screen with 8 scanlines per row and a 1 KiB RAM.
package txd_pkg;
    localparam int DOT_W  = 3;                        // dots per character = 2**DOT_W
    localparam int COL_W  = 5;                        // columns per line  = 2**COL_W
    localparam int SCAN_W = 3;                        // scanlines per row = 2**SCAN_W
    localparam int ROW_W  = 4;                        // text rows         = 2**ROW_W
    localparam int CNT_W  = COL_W + SCAN_W + ROW_W;   // position counter width
    localparam int ADDR_W = 10;                       // RAM address width
    localparam int DATA_W = 8;                        // RAM data / glyph row width
    localparam int SCAN_LO = COL_W;                   // lowest scanline bit in the counter
    localparam int ROW_LO  = COL_W + SCAN_W;          // lowest row bit in the counter
endpackage

// File: rtl/txd_timing.sv
// Module: txd_timing
// Divider chain: a dot counter divides the clock by eight, and a position
// counter steps once per character. Also decodes the horizontal blanking window.
// Assumes the clock is the dot clock and reset is synchronous, active low.
module txd_timing
    import txd_pkg::*;
#(
    parameter int HBLANK_COLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] pos_next,
    output logic             char_last,
    output logic             hblank
);
    localparam int              COLS     = 1 << COL_W;
    localparam logic [COL_W-1:0] HB_START = COL_W'(COLS - HBLANK_COLS);

    logic [DOT_W-1:0] dot;

    // Advance the dot counter each clock and the position counter after the last dot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot <= '0;
            pos <= '0;
        end else begin
            dot <= dot + 1'b1;
            if (char_last) pos <= pos_next;
        end
    end

    // Decode the end of a character, the next position and the blanking columns.
    always_comb begin
        char_last = (dot == '1);
        pos_next  = pos + 1'b1;
        hblank    = (pos[COL_W-1:0] >= HB_START);
    end

    // R2: the position steps by one after the last dot and holds otherwise.
    p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_last |=> pos == CNT_W'($past(pos) + 1'b1));
    p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !char_last |=> $stable(pos));
    // R2: exactly eight dots per character.
    p_dot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_last |=> dot == '0);
endmodule

// File: rtl/txd_ram_arb.sv
// Module: txd_ram_arb
// Shared 1024 x 8 RAM split by half-cycle. When cpu_half is high the processor
// port owns the address and may write; when it is low the display fetch reads.
// Assumes cpu_half alternates every clock.
module txd_ram_arb
    import txd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DISP_BASE = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_half,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_code
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ram_addr;

    // Select the owner of the single RAM address port for this half-cycle.
    assign ram_addr = cpu_half ? cpu_addr : disp_addr;

    // Store processor writes, only in the processor half.
    always_ff @(posedge clk) begin
        if (rst_n && cpu_half && cpu_we) mem[ram_addr] <= cpu_wdata;
    end

    // Capture read data for whichever side owns this half-cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
            disp_code <= '0;
        end else if (cpu_half) begin
            cpu_rdata <= mem[ram_addr];
        end else begin
            disp_code <= mem[ram_addr];
        end
    end

    // R5: the display side only ever addresses the character region.
    p_disp_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_half |-> ram_addr >= DISP_BASE);
    // R4: processor read data holds across a display half-cycle.
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_half |=> $stable(cpu_rdata));
endmodule

// File: rtl/txd_glyph_rom.sv
// Module: txd_glyph_rom
// Combinational glyph table: one pixel row per code and scanline for a small
// test character set, with a boxed outline for every code not in the set.
module txd_glyph_rom
    import txd_pkg::*;
(
    input  logic [DATA_W-1:0] code,
    input  logic [SCAN_W-1:0] scan,
    output logic [DATA_W-1:0] row_bits
);
    // Look up the pixel row for this code and scanline.
    always_comb begin
        unique case (code)
            8'h20:   row_bits = 8'h00;
            8'h7F:   row_bits = 8'hFF;
            8'h7C:   row_bits = 8'h18;
            8'h2D:   row_bits = (scan == 3'd3) ? 8'hFF : 8'h00;
            8'h23:   row_bits = scan[0] ? 8'h55 : 8'hAA;
            default: row_bits = (scan == '0 || scan == '1) ? 8'hFF : 8'h81;
        endcase
    end
endmodule

// File: rtl/txd_pixel_shift.sv
// Module: txd_pixel_shift
// Parallel-load shift register that serialises one glyph row, MSB first.
// The register loads on the last dot of a character and shifts on every other
// dot. The output is forced dark while blanking.
module txd_pixel_shift
    import txd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] row_bits,
    input  logic              blank,
    output logic              pixel
);
    logic [DATA_W-1:0] shreg;

    // Load a fresh row at the character boundary, otherwise shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= row_bits;
        else           shreg <= {shreg[DATA_W-2:0], 1'b0};
    end

    // Drive the top bit unless blanking.
    assign pixel = shreg[DATA_W-1] & ~blank;

    // R6: the first dot of a character shows the top bit of the loaded row.
    p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> shreg[DATA_W-1] == $past(row_bits[DATA_W-1]));
    // R8: no lit pixel during blanking.
    p_blank_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !pixel);
endmodule

// File: rtl/txd_display.sv
// Module: txd_display (top)
// Shared-RAM text display controller. It fetches the next position's code in
// the display half-cycles, looks up its glyph row, and loads the row into the
// pixel shifter at the last dot of the current character.
// Assumes clk is the dot clock and cpu_half toggles every clock.
module txd_display
    import txd_pkg::*;
#(
    parameter int                HBLANK_COLS = 4,
    parameter logic [ADDR_W-1:0] DISP_BASE   = 10'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_half,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              video,
    output logic              hsync,
    output logic              frame_sync
);
    logic [CNT_W-1:0]  pos, pos_next;
    logic              char_last, hblank;
    logic [ADDR_W-1:0] disp_addr;
    logic [DATA_W-1:0] disp_code, row_bits;

    txd_timing #(.HBLANK_COLS(HBLANK_COLS)) u_timing (
        .clk(clk), .rst_n(rst_n), .pos(pos), .pos_next(pos_next),
        .char_last(char_last), .hblank(hblank)
    );

    // Address of the next character: base + row * columns + column.
    assign disp_addr = DISP_BASE
                     + ADDR_W'({pos_next[CNT_W-1:ROW_LO], pos_next[COL_W-1:0]});

    txd_ram_arb #(.DISP_BASE(DISP_BASE)) u_ram (
        .clk(clk), .rst_n(rst_n), .cpu_half(cpu_half), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .disp_addr(disp_addr), .disp_code(disp_code)
    );

    txd_glyph_rom u_glyph (
        .code(disp_code), .scan(pos_next[ROW_LO-1:SCAN_LO]), .row_bits(row_bits)
    );

    txd_pixel_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(char_last), .row_bits(row_bits),
        .blank(hblank), .pixel(video)
    );

    // Line and frame markers taken straight from the position counter.
    assign hsync      = hblank;
    assign frame_sync = (pos == '0);

    // R3: the phase flag must alternate every clock once out of reset.
    p_half_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cpu_half != $past(cpu_half));
    // R9: the frame marker lasts exactly one character time.
    p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && char_last) |=> !frame_sync);
endmodule

// File: tb/txd_display_test.sv
// Bench for txd_display: a vector table for the processor port, then directed
// checks on reset, line timing and one full frame of pixels.
module txd_display_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_half = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_rdata;
    logic       video, hsync, frame_sync;

    int tests = 0;
    int fails = 0;
    int n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Phase flag toggles every dot clock, independent of reset.
    always @(posedge clk) cpu_half <= ~cpu_half;
    // Cycle index since reset release.
    always @(posedge clk) n <= rst_n ? n + 1 : 0;

    txd_display uut (
        .clk(clk), .rst_n(rst_n), .cpu_half(cpu_half), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .video(video), .hsync(hsync), .frame_sync(frame_sync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Glyph rows as listed in R7.
    function automatic logic [7:0] glyph(input logic [7:0] code, input int scan);
        case (code)
            8'h20:   return 8'h00;
            8'h7F:   return 8'hFF;
            8'h7C:   return 8'h18;
            8'h2D:   return (scan == 3) ? 8'hFF : 8'h00;
            8'h23:   return (scan % 2 == 1) ? 8'h55 : 8'hAA;
            default: return (scan == 0 || scan == 7) ? 8'hFF : 8'h81;
        endcase
    endfunction

    // Screen pattern written into the display region.
    function automatic logic [7:0] code_at(input int idx);
        case ((idx * 7 + idx / 32) % 6)
            0: return 8'h20;
            1: return 8'h7F;
            2: return 8'h7C;
            3: return 8'h2D;
            4: return 8'h23;
            default: return 8'h41;
        endcase
    endfunction

    task automatic to_cpu_slot();
        @(negedge clk);
        while (!cpu_half) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [9:0] a, input logic [7:0] d);
        to_cpu_slot();
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [9:0] a, output logic [7:0] d);
        to_cpu_slot();
        cpu_addr = a; cpu_we = 1'b0;
        @(negedge clk);
        d = cpu_rdata;
    endtask

    task automatic wait_cycle(input int k);
        while (n != k) @(negedge clk);
    endtask

    // Processor-port vectors: {is_write, address, data or expected read}.
    localparam int NVEC = 10;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 10'h000, 8'h3C}, {1'b1, 10'h3FF, 8'hC3}, {1'b1, 10'h1FF, 8'h5A},
        {1'b1, 10'h200, 8'h81}, {1'b0, 10'h000, 8'h3C}, {1'b0, 10'h3FF, 8'hC3},
        {1'b1, 10'h000, 8'hE7}, {1'b0, 10'h000, 8'hE7}, {1'b0, 10'h1FF, 8'h5A},
        {1'b0, 10'h200, 8'h81}
    };

    initial begin
        #(4 * 190000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int bad_pix, bad_hs, bad_fs;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(video == 1'b0, "R1 video", video, 0);
        check(hsync == 1'b0, "R1 hsync", hsync, 0);
        check(frame_sync == 1'b1, "R1 frame_sync", frame_sync, 1);
        check(cpu_rdata == 8'h00, "R1 cpu_rdata", cpu_rdata, 0);
        rst_n = 1'b1;

        // R6: position 0 of the first frame is dark; R9 marker spans 8 dots.
        bad_pix = 0;
        for (int k = 0; k < 8; k++) begin
            wait_cycle(k);
            if (video !== 1'b0) bad_pix++;
        end
        check(bad_pix == 0, "R6 first position dark", bad_pix, 0);
        check(frame_sync == 1'b1, "R9 frame_sync at n=7", frame_sync, 1);
        wait_cycle(8);
        check(frame_sync == 1'b0, "R9 frame_sync at n=8", frame_sync, 0);

        // R2 R8: blanking starts at column 28 and ends at the next line.
        wait_cycle(223);
        check(hsync == 1'b0, "R2 R8 hsync before col 28", hsync, 0);
        wait_cycle(224);
        check(hsync == 1'b1, "R2 R8 hsync at col 28", hsync, 1);
        wait_cycle(255);
        check(hsync == 1'b1, "R8 hsync at col 31 last dot", hsync, 1);
        wait_cycle(256);
        check(hsync == 1'b0, "R2 R8 hsync after wrap to col 0", hsync, 0);

        // R4 R10: vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][18]) begin
                cpu_write(VEC[i][17:8], VEC[i][7:0]);
            end else begin
                cpu_read(VEC[i][17:8], rd);
                check(rd == VEC[i][7:0], "R4 R10 read back", rd, VEC[i][7:0]);
            end
        end

        // R3: a write presented in the display half is ignored.
        cpu_write(10'h055, 8'hA5);
        @(negedge clk);
        while (cpu_half) @(negedge clk);
        cpu_addr = 10'h055; cpu_wdata = 8'h5A; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        cpu_read(10'h055, rd);
        check(rd == 8'hA5, "R3 display-half write ignored", rd, 8'hA5);

        // Fill the display region for the frame check.
        for (int i = 0; i < 512; i++) cpu_write(10'h200 + 10'(i), code_at(i));

        // R2 R5 R6 R7 R8 R9: compare the whole second frame, one check per text row.
        wait_cycle(32768);
        for (int r = 0; r < 16; r++) begin
            bad_pix = 0; bad_hs = 0; bad_fs = 0;
            for (int c = 0; c < 2048; c++) begin
                int p, d, col, scan, row;
                logic exp_pix;
                wait_cycle(32768 + r * 2048 + c);
                p = ((n / 8) % 4096); d = n % 8;
                col = p % 32; scan = (p / 32) % 8; row = p / 256;
                exp_pix = (col >= 28) ? 1'b0 : glyph(code_at(row * 32 + col), scan)[7 - d];
                if (video !== exp_pix) bad_pix++;
                if (hsync !== (col >= 28)) bad_hs++;
                if (frame_sync !== (p == 0)) bad_fs++;
            end
            check(bad_pix == 0, $sformatf("R5 R6 R7 pixels row %0d", r), bad_pix, 0);
            check(bad_hs == 0, $sformatf("R8 hsync row %0d", r), bad_hs, 0);
            check(bad_fs == 0, $sformatf("R2 R9 frame_sync row %0d", r), bad_fs, 0);
        end

        // R1: reset mid-frame returns to the reset state.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(video == 1'b0 && hsync == 1'b0, "R1 outputs after mid-frame reset",
              {video, hsync}, 0);
        check(frame_sync == 1'b1, "R1 position cleared", frame_sync, 1);
        check(cpu_rdata == 8'h00, "R1 read data cleared", cpu_rdata, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule